// File: doc/BRIEF.md
# Endian-Switchable Load/Store Aligner

This block sits between a 32-bit core and a memory that is only ever read or written as whole words. On a load, the fetched word enters together with the two low address bits, an access size and a signedness flag. The block picks out the addressed bytes and returns them right-justified in a register-sized result, sign- or zero-extended. On a store, it moves the low bytes of the register operand into the lanes that the address selects and raises one write enable for each lane written.

The byte order is chosen per access. A base order is captured from an input pin while reset is held and stays fixed until the next reset. A reverse-order control bit can flip that order, but only for accesses made in user mode. Kernel-mode accesses always use the base order, whatever address they target. Apart from the register that holds the base order, the block is combinational. Halfword accesses at an odd offset, word accesses at a nonzero offset, and three-byte accesses that would run past the end of the word are flagged as misaligned and write nothing.

Top module: `lsu_lane_aligner`

## Requirements
- R1: `base_big_in` is captured on every rising clock edge while `rst_n` is low (1 = big-endian). After reset is released the captured order holds, and changes on `base_big_in` have no effect on `eff_big` until the next reset.
- R2: In user mode (`user_mode`=1), the effective order is the base order XOR `rev_endian`. `eff_big` reports it, with 1 meaning big-endian.
- R3: In kernel mode (`user_mode`=0), `rev_endian` is ignored and the effective order equals the base order.
- R4: Physical lane L is bits 8L+7:8L. In little-endian order, byte offset a maps to lane a. In big-endian order, it maps to lane 3-a, so offset 0 selects bits 31:24.
- R5: A byte load (`acc_size`=2'b00) returns the selected lane in `ld_result[7:0]`.
- R6: A partial load (byte, halfword or three-byte) with `ld_signed`=1 copies the most significant loaded bit into all upper result bits. With `ld_signed`=0 the upper bits are zero. A word load ignores `ld_signed`.
- R7: Three-byte accesses (`acc_size`=2'b10) are legal at offsets 0 and 1. The byte at the lowest address is the least significant byte in little-endian order and the most significant byte in big-endian order; the same holds for halfwords (`acc_size`=2'b01) and words (2'b11).
- R8: On a store, byte i of `st_data` (for i below the access length) goes to the lane of the address it belongs to, following the R7 significance rule. All lanes that are not enabled read zero in `st_word`.
- R9: When the access is aligned, `st_byte_en` has exactly one bit set for each byte of the access, at the lanes those bytes occupy.
- R10: A halfword at an odd offset, a word at a nonzero offset, or a three-byte access at offset 2 or 3 sets `misaligned`. It also forces `st_byte_en`, `st_word` and `ld_result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the base-order register |
| rst_n | input | 1 | Synchronous active-low reset; base order is sampled while low |
| base_big_in | input | 1 | Base byte order to capture during reset (1 = big) |
| user_mode | input | 1 | Access is made in user mode |
| rev_endian | input | 1 | Reverse-order status bit |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 three bytes, 11 word |
| addr_lo | input | 2 | Byte offset within the word |
| ld_signed | input | 1 | Sign-extend partial loads |
| ld_word | input | 32 | Word fetched from memory |
| st_data | input | 32 | Register operand for stores |
| ld_result | output | 32 | Aligned, extended load value |
| st_word | output | 32 | Store data placed in its lanes |
| st_byte_en | output | 4 | Per-lane write enables |
| misaligned | output | 1 | Access overruns its natural alignment |
| eff_big | output | 1 | Effective byte order of this access (1 = big) |

## Verification
On every cycle, the assertions check the following:
- the base order is stable once reset is released;
- kernel-mode accesses follow the base order, and user-mode accesses with the reverse bit set follow the opposite order;
- a misaligned access drives all enables and data to zero;
- an aligned access enables exactly as many lanes as its size.

Some properties cannot be judged cycle by cycle without restating the lane logic, and only the bench scenarios show them. These are which lanes are chosen, the byte significance within a multi-byte value, the extension bits, and that the captured order survives a change on `base_big_in` after reset. The bench sweeps every size, offset, signedness, mode and reverse-bit combination under both base orders, and computes expected values from a byte-addressed model.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int CNT_W      = OFF_W + 1;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_TRIP = 2'd2,
    ACC_WORD = 2'd3
  } acc_size_e;

  // Number of bytes moved by an access of the given size.
  function automatic logic [CNT_W-1:0] size_to_bytes(acc_size_e s);
    return CNT_W'(s) + CNT_W'(1);
  endfunction

  // True when the access does not fit its natural alignment in the word.
  function automatic logic span_overruns(acc_size_e s, logic [OFF_W-1:0] off);
    logic bad;
    case (s)
      ACC_BYTE: bad = 1'b0;
      ACC_HALF: bad = off[0];
      ACC_TRIP: bad = (int'(off) + 3) > WORD_BYTES;
      default:  bad = (off != '0);
    endcase
    return bad;
  endfunction

  // Physical lane holding the least significant byte of the access.
  function automatic logic [OFF_W-1:0] lowest_lane(acc_size_e s,
                                                   logic [OFF_W-1:0] off,
                                                   logic big);
    int t;
    if (big) t = WORD_BYTES - int'(off) - int'(size_to_bytes(s));
    else     t = int'(off);
    return OFF_W'(t);
  endfunction

  // Contiguous run of n enabled lanes starting at lane low.
  function automatic logic [WORD_BYTES-1:0] lane_run(logic [CNT_W-1:0] n,
                                                     logic [OFF_W-1:0] low);
    logic [2*WORD_BYTES-1:0] t;
    t = ((2*WORD_BYTES)'(1) << n) - (2*WORD_BYTES)'(1);
    t = t << low;
    return t[WORD_BYTES-1:0];
  endfunction
endpackage

// File: rtl/endian_ctrl.sv
module endian_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic base_big_in,
  input  logic user_mode,
  input  logic rev_endian,
  output logic eff_big
);
  logic base_big;
  logic rev_active;

  always_ff @(posedge clk) begin
    if (!rst_n) base_big <= base_big_in;
  end

  assign rev_active = rev_endian & user_mode;
  assign eff_big    = base_big ^ rev_active;

  // R1
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(base_big));

  // R3
  kernel_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> (eff_big == base_big));

  // R2
  user_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && rev_endian) |-> (eff_big != base_big));
endmodule

// File: rtl/lane_decoder.sv
module lane_decoder
  import aligner_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  acc_size_e             size,
  input  logic [OFF_W-1:0]      off,
  input  logic                  eff_big,
  output logic [OFF_W-1:0]      low_lane,
  output logic [CNT_W-1:0]      nbytes,
  output logic [WORD_BYTES-1:0] lane_mask,
  output logic                  misaligned
);
  logic [WORD_BYTES-1:0] raw_run;

  always_comb begin
    nbytes     = size_to_bytes(size);
    misaligned = span_overruns(size, off);
    low_lane   = lowest_lane(size, off, eff_big);
    raw_run    = lane_run(nbytes, low_lane);
    lane_mask  = misaligned ? '0 : raw_run;
  end

  // R10
  misalign_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (lane_mask == '0));

  // R9
  mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !misaligned |-> ($countones(lane_mask) == int'(nbytes)));

  // R4
  byte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size == ACC_BYTE) |-> $onehot0(lane_mask) && (lane_mask != '0));
endmodule

// File: rtl/load_extract.sv
module load_extract
  import aligner_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic [OFF_W-1:0]  low_lane,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              is_signed,
  input  logic              misaligned,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] shifted;
  logic              sign_bit;
  logic [BYTE_W-1:0] fill;

  always_comb begin
    shifted  = word >> (BYTE_W * int'(low_lane));
    sign_bit = 1'b0;
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (k == int'(nbytes) - 1) sign_bit = shifted[BYTE_W*k + BYTE_W-1];
    end
    fill = (is_signed && sign_bit) ? '1 : '0;
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (misaligned)            result[BYTE_W*k +: BYTE_W] = '0;
      else if (k < int'(nbytes)) result[BYTE_W*k +: BYTE_W] = shifted[BYTE_W*k +: BYTE_W];
      else                       result[BYTE_W*k +: BYTE_W] = fill;
    end
  end

  // R6
  unsigned_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_signed && !misaligned && nbytes == CNT_W'(1)) |->
      (result[WORD_W-1:BYTE_W] == '0));

  // R10
  misalign_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (result == '0));
endmodule

// File: rtl/store_place.sv
module store_place
  import aligner_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_W-1:0]     data,
  input  logic [OFF_W-1:0]      low_lane,
  input  logic [WORD_BYTES-1:0] lane_mask,
  output logic [WORD_W-1:0]     st_word,
  output logic [WORD_BYTES-1:0] byte_en
);
  logic [WORD_W-1:0] shifted;

  assign shifted = data << (BYTE_W * int'(low_lane));
  assign byte_en = lane_mask;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign st_word[BYTE_W*g +: BYTE_W] =
      lane_mask[g] ? shifted[BYTE_W*g +: BYTE_W] : '0;
  end

  // R8
  idle_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en == '0) |-> (st_word == '0));
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
  import aligner_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_big_in,
  input  logic              user_mode,
  input  logic              rev_endian,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        addr_lo,
  input  logic              ld_signed,
  input  logic [31:0]       ld_word,
  input  logic [31:0]       st_data,
  output logic [31:0]       ld_result,
  output logic [31:0]       st_word,
  output logic [3:0]        st_byte_en,
  output logic              misaligned,
  output logic              eff_big
);
  acc_size_e             size_e;
  logic [OFF_W-1:0]      low_lane;
  logic [CNT_W-1:0]      nbytes;
  logic [WORD_BYTES-1:0] lane_mask;

  assign size_e = acc_size_e'(acc_size);

  endian_ctrl u_endian (
    .clk(clk), .rst_n(rst_n), .base_big_in(base_big_in),
    .user_mode(user_mode), .rev_endian(rev_endian), .eff_big(eff_big)
  );

  lane_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .size(size_e), .off(addr_lo),
    .eff_big(eff_big), .low_lane(low_lane), .nbytes(nbytes),
    .lane_mask(lane_mask), .misaligned(misaligned)
  );

  load_extract u_ld (
    .clk(clk), .rst_n(rst_n), .word(ld_word), .low_lane(low_lane),
    .nbytes(nbytes), .is_signed(ld_signed), .misaligned(misaligned),
    .result(ld_result)
  );

  store_place u_st (
    .clk(clk), .rst_n(rst_n), .data(st_data), .low_lane(low_lane),
    .lane_mask(lane_mask), .st_word(st_word), .byte_en(st_byte_en)
  );
endmodule

// File: tb/lsu_lane_aligner_tb.sv
`timescale 1ns/1ps
module lsu_lane_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_big_in, user_mode, rev_endian, ld_signed;
  logic [1:0]  acc_size, addr_lo;
  logic [31:0] ld_word, st_data;
  logic [31:0] ld_result, st_word;
  logic [3:0]  st_byte_en;
  logic        misaligned, eff_big;

  int n_checks = 0;
  int n_fail   = 0;
  logic base_exp;

  typedef struct {
    logic [31:0] ld;
    logic [31:0] st;
    logic [3:0]  en;
    logic        mis;
    logic        big;
    logic        usr;
    string       ld_tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  lsu_lane_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .base_big_in(base_big_in),
    .user_mode(user_mode), .rev_endian(rev_endian), .acc_size(acc_size),
    .addr_lo(addr_lo), .ld_signed(ld_signed), .ld_word(ld_word),
    .st_data(st_data), .ld_result(ld_result), .st_word(st_word),
    .st_byte_en(st_byte_en), .misaligned(misaligned), .eff_big(eff_big)
  );

  task automatic check32(string req, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic do_reset(logic b);
    @(negedge clk);
    rst_n = 1'b0; base_big_in = b; user_mode = 1'b0; rev_endian = 1'b0;
    acc_size = 2'd0; addr_lo = 2'd0; ld_signed = 1'b0;
    ld_word = '0; st_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base_exp = b;
  endtask

  // Driver: apply one access and push its independently built expectation.
  task automatic drive(logic [1:0] sz, logic [1:0] off, logic sgn, logic usr,
                       logic rev, logic [31:0] w, logic [31:0] d);
    exp_t e;
    int   n, a, lane, pos;
    @(negedge clk);
    acc_size = sz; addr_lo = off; ld_signed = sgn; user_mode = usr;
    rev_endian = rev; ld_word = w; st_data = d;
    n = int'(sz) + 1;
    e.big = base_exp ^ (rev & usr);
    e.usr = usr;
    e.ld = '0; e.st = '0; e.en = '0;
    e.mis = (n == 2 && off[0]) || (n == 4 && off != 0) || (n == 3 && int'(off) + 3 > 4);
    if (n == 1)      e.ld_tag = sgn ? "R5 R6" : "R4 R5";
    else if (n == 3) e.ld_tag = "R7";
    else             e.ld_tag = sgn ? "R6" : "R7";
    if (e.mis) e.ld_tag = "R10";
    if (!e.mis) begin
      for (int i = 0; i < n; i++) begin
        a    = int'(off) + i;
        lane = e.big ? 3 - a : a;
        pos  = e.big ? n - 1 - i : i;
        e.ld[8*pos +: 8]  = w[8*lane +: 8];
        e.en[lane]        = 1'b1;
        e.st[8*lane +: 8] = d[8*pos +: 8];
      end
      if (sgn && n < 4 && e.ld[8*n-1]) begin
        for (int b = 8*n; b < 32; b++) e.ld[b] = 1'b1;
      end
    end
    exp_q.push_back(e);
    -> chk_ev;
  endtask

  // Monitor: compare design outputs against the queued expectation.
  initial begin
    exp_t e;
    forever begin
      @(chk_ev);
      #1;
      e = exp_q.pop_front();
      check32(e.ld_tag, ld_result, e.ld);
      check32(e.mis ? "R10" : "R8", st_word, e.st);
      check32(e.mis ? "R10" : "R9", {28'd0, st_byte_en}, {28'd0, e.en});
      check32("R10", {31'd0, misaligned}, {31'd0, e.mis});
      check32(e.usr ? "R2" : "R3", {31'd0, eff_big}, {31'd0, e.big});
    end
  end

  task automatic sweep(logic [31:0] w, logic [31:0] d);
    for (int u = 0; u < 2; u++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 4; s++)
          for (int o = 0; o < 4; o++)
            for (int g = 0; g < 2; g++)
              drive(2'(s), 2'(o), 1'(g), 1'(u), 1'(r), w, d);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // Reset state, big-endian base (R1)
    do_reset(1'b1);
    #1;
    check32("R1", {31'd0, eff_big}, 32'd1);
    // Base input toggled after reset must be ignored (R1)
    @(negedge clk); base_big_in = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check32("R1", {31'd0, eff_big}, 32'd1);
    sweep(32'h8CF17EA5, 32'hD46AB107);
    sweep(32'h3B9642E8, 32'h19E3C27F);
    // Little-endian base
    do_reset(1'b0);
    @(negedge clk); base_big_in = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check32("R1", {31'd0, eff_big}, 32'd0);
    sweep(32'h8CF17EA5, 32'hD46AB107);
    sweep(32'h7F80FF01, 32'hA55A0FF0);
    // Explicit corner: LE byte at offset 0 selects bits 7:0 (R4)
    drive(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h11223344, 32'h0);
    // Explicit corner: user reverse flips to big, offset 0 selects 31:24 (R4)
    drive(2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 32'h11223344, 32'h0);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule